// File: doc/BRIEF.md
# Radix-4 Sequential Unsigned Multiplier with Carry-Digit Recoding

This block multiplies two unsigned operands of `WIDTH` bits, where `WIDTH` is even, using a right-shifting accumulator. Each clock cycle it consumes two multiplier bits as one radix-4 digit and adds one multiple of the multiplicand to the running partial product. It then moves the two lowest result bits into a low-half register.

A digit of value 3 would normally need a precomputed triple of the multiplicand. This design never builds that triple. It subtracts the multiplicand and passes a carry of one into the next digit, because three times a equals four times a minus a. The multiple selector therefore only chooses among zero, a, twice a and minus a. The carry is held in a flip-flop between iterations.

After the last digit, one more cycle absorbs any pending carry by adding the multiplicand at the top digit position. That cycle also writes the full `2*WIDTH`-bit product to the output register. A caller pulses `start` with both operands while the block is idle. It then waits for the one-cycle `done` pulse and reads `product`, which holds its value until the next operation completes.

Top module: `mul4_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy` is 0, `done` is 0 and `product` is 0.
- R2: When `start` is 1 at a clock edge while `busy` is 0, the block captures `a_in` and `x_in` and `busy` reads 1 after that edge.
- R3: If a start is accepted at edge n, `busy` stays 1 after edges n through n+WIDTH/2 and `done` is 0 in those cycles. After edge n+WIDTH/2+1, `done` is 1 and `busy` is 0 for exactly one cycle. After the following edge `done` is 0 again.
- R4: When `done` is 1, `product` equals the exact unsigned product of the captured operands as a 2*WIDTH-bit number, including all-ones operands.
- R5: A multiplier digit (bit pair 2i+1:2i) whose value plus the incoming carry equals 3 is applied as minus the multiplicand with a carry of one into the next digit. A sum of 4 applies zero with a carry of one. Either way, the final product is unaffected, for example with an all-ones multiplier.
- R6: A carry leaving the most significant digit is absorbed in the final cycle by adding the multiplicand at weight 4^(WIDTH/2), so multipliers whose top bit pair is 11 still give exact products.
- R7: A digit of value 2 applies twice the multiplicand, so alternating 10 bit-pair multipliers give exact products.
- R8: A `start` seen while `busy` is 1 is ignored. The running operation finishes at its original time with the product of its original operands, and no second operation begins.
- R9: `product` keeps its value from one completion until the next completion, whatever the inputs do meanwhile.
- R10: A zero multiplicand or zero multiplier gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new multiplication; taken only while idle |
| a_in | input | WIDTH | Unsigned multiplicand |
| x_in | input | WIDTH | Unsigned multiplier |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: `product` has just been updated |
| product | output | 2*WIDTH | Unsigned product of the last completed operation |

## Verification
Several kinds of internal fault show up at the ports in a specific way:
- A wrong recoded digit, or a lost or stuck carry flip-flop, leaves no visible trace while the block is busy. It appears at the single `done` cycle as a product that differs from a*x. Those differences are multiples of the multiplicand times a power of four, so multipliers that are all ones, have a top bit pair of 11, or repeat the bit pair 10 expose each recoding path.
- A faulty iteration counter moves the `done` pulse earlier or later than WIDTH/2+1 cycles after the start. That error is visible in the first operation.
- A control path that accepts a second start while busy shows as a shifted `done` or a product of the wrong operands.

// File: rtl/mul4_pkg.sv
package mul4_pkg;

    // Which multiple of the multiplicand is added in one iteration
    typedef enum logic [1:0] {
        SEL_ZERO = 2'd0,
        SEL_ONE  = 2'd1,
        SEL_TWO  = 2'd2,
        SEL_NEG  = 2'd3
    } sel_e;

    // Outcome of recoding one radix-4 digit together with the incoming carry
    typedef struct packed {
        sel_e sel;
        logic cout;
    } recode_t;

    // The effective digit is the bit pair plus the carry, a value from 0 to 4.
    // A value of 3 becomes -1 here plus 4 in the next digit. A value of 4
    // becomes 0 here plus 4 in the next digit.
    function automatic recode_t recode_digit(input logic [1:0] bits, input logic cin);
        logic [2:0] eff;
        recode_t    r;
        eff = {1'b0, bits} + {2'b00, cin};
        case (eff)
            3'd0:    begin r.sel = SEL_ZERO; r.cout = 1'b0; end
            3'd1:    begin r.sel = SEL_ONE;  r.cout = 1'b0; end
            3'd2:    begin r.sel = SEL_TWO;  r.cout = 1'b0; end
            3'd3:    begin r.sel = SEL_NEG;  r.cout = 1'b1; end
            default: begin r.sel = SEL_ZERO; r.cout = 1'b1; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mul4_recoder.sv
module mul4_recoder
    import mul4_pkg::*;
(
    input  logic [1:0] digit,
    input  logic       cin,
    output sel_e       sel,
    output logic       cout
);

    recode_t rec;

    always_comb begin
        rec  = recode_digit(digit, cin);
        sel  = rec.sel;
        cout = rec.cout;
    end

endmodule

// File: rtl/mul4_multiple.sv
module mul4_multiple
    import mul4_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int AW    = WIDTH + 3
) (
    input  logic [WIDTH-1:0]     a,
    input  sel_e                 sel,
    output logic signed [AW-1:0] mult
);

    localparam int PAD = AW - WIDTH;

    logic [AW-1:0] a_ext;

    // Zero-extend the multiplicand into the accumulator width
    assign a_ext = {{PAD{1'b0}}, a};

    always_comb begin
        case (sel)
            SEL_ONE:  mult = a_ext;
            SEL_TWO:  mult = a_ext << 1;
            SEL_NEG:  mult = -a_ext;
            default:  mult = '0;
        endcase
    end

endmodule

// File: rtl/mul4_ctrl.sv
module mul4_ctrl #(
    parameter int DIGITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic load,
    output logic step,
    output logic absorb,
    output logic done
);

    localparam int CW = $clog2(DIGITS + 1);
    localparam logic [CW-1:0] LAST = CW'(DIGITS);

    logic [CW-1:0] cnt;

    assign load   = start && !busy;
    assign step   = busy && (cnt != LAST);
    assign absorb = busy && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= absorb;
            if (load) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (absorb) begin
                busy <= 1'b0;
            end else if (step) begin
                cnt  <= cnt + 1'b1;
            end
        end
    end

    // R3: the iteration counter never runs past the absorb step
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R3: done only follows a busy cycle
    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R3: done lasts a single cycle
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: busy only rises in response to a start request
    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/mul4_seq.sv
module mul4_seq
    import mul4_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIDTH-1:0]   a_in,
    input  logic [WIDTH-1:0]   x_in,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);

    localparam int DIGITS = WIDTH / 2;
    localparam int AW     = WIDTH + 3;

    logic load, step, absorb;

    logic [WIDTH-1:0]     a_q;
    logic [WIDTH-1:0]     x_q;
    logic [WIDTH-1:0]     low_q;
    logic signed [AW-1:0] acc_q;
    logic                 carry_q;

    sel_e                 sel;
    logic                 cout;
    logic signed [AW-1:0] mult;
    logic signed [AW-1:0] sum;
    logic signed [AW-1:0] fin;

    mul4_ctrl #(.DIGITS(DIGITS)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .busy   (busy),
        .load   (load),
        .step   (step),
        .absorb (absorb),
        .done   (done)
    );

    mul4_recoder u_rec (
        .digit (x_q[1:0]),
        .cin   (carry_q),
        .sel   (sel),
        .cout  (cout)
    );

    // In the absorb step the lowest digit is not used: a pending carry
    // selects plain a, otherwise zero
    sel_e sel_eff;
    assign sel_eff = absorb ? (carry_q ? SEL_ONE : SEL_ZERO) : sel;

    mul4_multiple #(.WIDTH(WIDTH), .AW(AW)) u_mult (
        .a    (a_q),
        .sel  (sel_eff),
        .mult (mult)
    );

    assign sum = acc_q + mult;
    assign fin = sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            x_q     <= '0;
            low_q   <= '0;
            acc_q   <= '0;
            carry_q <= 1'b0;
            product <= '0;
        end else if (load) begin
            a_q     <= a_in;
            x_q     <= x_in;
            low_q   <= '0;
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (step) begin
            acc_q   <= sum >>> 2;
            low_q   <= {sum[1:0], low_q[WIDTH-1:2]};
            x_q     <= x_q >> 2;
            carry_q <= cout;
        end else if (absorb) begin
            product <= {fin[WIDTH-1:0], low_q};
            carry_q <= 1'b0;
        end
    end

    // R4: the final high half is non-negative and fits in WIDTH bits
    a_r4_final_fits: assert property (@(posedge clk) disable iff (rst)
        absorb |-> (fin[AW-1:WIDTH] == '0));

    // R9: the product register only changes when done is raised
    a_r9_product_hold: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(product));

    // R5: the carry flip-flop is clear whenever the block is idle
    a_r5_carry_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(rst)) |-> !carry_q);

endmodule

// File: tb/sim_mul4_seq.sv
module sim_mul4_seq;

    localparam int W  = 16;
    localparam int M  = W / 2;
    localparam int NV = 12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [W-1:0]   a_in = '0;
    logic [W-1:0]   x_in = '0;
    logic           busy;
    logic           done;
    logic [2*W-1:0] product;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mul4_seq #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .a_in(a_in), .x_in(x_in),
        .busy(busy), .done(done), .product(product)
    );

    // Operand pairs: {a, x}
    localparam logic [2*W-1:0] VEC [NV] = '{
        {16'h0001, 16'h0001},   // basic
        {16'hFFFF, 16'hFFFF},   // R5 all ones, R6 top carry
        {16'h1234, 16'hFFFF},   // R5
        {16'hFFFF, 16'h0001},
        {16'hABCD, 16'hAAAA},   // R7 digit 2
        {16'h0007, 16'hC000},   // R6 top pair 11
        {16'hFFFF, 16'hC000},   // R6
        {16'h8001, 16'h5555},
        {16'h0000, 16'hFFFF},   // R10
        {16'hFFFF, 16'h0000},   // R10
        {16'h0003, 16'h0003},
        {16'h5A5A, 16'h7BDF}    // mixed carries
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Start at the current cycle, then step through the whole operation
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] x, input string req);
        logic [2*W-1:0] exp;
        exp   = {{W{1'b0}}, a} * {{W{1'b0}}, x};
        start = 1'b1; a_in = a; x_in = x;
        @(posedge clk); #1;
        start = 1'b0; a_in = ~a; x_in = ~x;
        check("R2 busy after start", 64'(busy), 64'd1);
        repeat (M) begin
            @(posedge clk); #1;
            if (done !== 1'b0 || busy !== 1'b1) check("R3 still busy", {busy, done}, 64'b10);
        end
        @(posedge clk); #1;
        check("R3 done pulse", {busy, done}, 64'b01);
        check({req, " product"}, 64'(product), 64'(exp));
        @(posedge clk); #1;
        check("R3 done drops", 64'(done), 64'd0);
        check("R9 product held", 64'(product), 64'(exp));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] lf;
        logic [2*W-1:0] exp0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset busy", 64'(busy), 64'd0);
        check("R1 reset done", 64'(done), 64'd0);
        check("R1 reset product", 64'(product), 64'd0);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1 after reset", {busy, done, product}, 64'd0);

        for (int i = 0; i < NV; i++)
            run(VEC[i][2*W-1:W], VEC[i][W-1:0], "R4 table");

        // R5/R6/R7 directed boundary operands
        run(16'hFFFF, 16'hFFFF, "R5 R6");
        run(16'h0001, 16'hAAAA, "R7");
        run(16'h0000, 16'h0000, "R10");

        // Pseudo-random sweep for R4
        lf = 16'hACE1;
        for (int i = 0; i < 20; i++) begin
            logic [W-1:0] b;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            b  = lf ^ 16'h3C3C;
            run(lf, b, "R4 sweep");
        end

        // R8: a second start during busy is ignored
        exp0  = 32'h0000_1234 * 32'h0000_00FF;
        start = 1'b1; a_in = 16'h1234; x_in = 16'h00FF;
        @(posedge clk); #1;
        start = 1'b1; a_in = 16'hFFFF; x_in = 16'hFFFF;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (M - 1) begin
            @(posedge clk); #1;
            if (done !== 1'b0) check("R8 no early done", 64'(done), 64'd0);
        end
        @(posedge clk); #1;
        check("R8 done on time", {busy, done}, 64'b01);
        check("R8 original product", 64'(product), 64'(exp0));
        repeat (M + 3) @(posedge clk);
        #1;
        check("R8 no second run", {busy, done}, 64'b00);
        check("R9 product after idle", 64'(product), 64'(exp0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule